// File: doc/BRIEF.md
# Banked Jack Information Register

This block keeps one 16-bit information word for every value of a 4-bit audio jack function code. Firmware chooses a function by writing a function-code field into a select register. Reads and writes to the information address then reach only the copy that belongs to that function. Each copy holds these fields:

- a gain field;
- a phase-inversion flag;
- a buffer-delay count, in 48 kHz sample periods;
- a sense-valid flag;
- a read-only function-present flag.

The function-present flag comes from a per-function capability input.

The banks belong to the power-on reset domain only. A codec (soft or hardware) reset clears the select register and the read-data path, and it does not touch any stored bank. Sensing logic outside the block pulses `sense_done` together with a function code. That pulse sets the valid flag of the named bank. Firmware clears the valid flag by writing 1 to it. If the function has no capability, the gain, inversion and delay fields read as zero and ignore writes. This also applies to a mono function while the tip/ring select bit is at ring.

Register accesses go through a small access state machine with two states. `AC_IDLE` holds no response. `AC_RESP` holds read data for one cycle. A read strobe in either state takes the `AC_IDLE->AC_RESP` or `AC_RESP->AC_RESP` transition. A cycle without a read takes the `AC_RESP->AC_IDLE` or `AC_IDLE->AC_IDLE` transition. Each bank's valid flag is a two-state machine. `IV_PENDING->IV_VALID` happens on a sense completion. `IV_VALID->IV_PENDING` happens on a write of 1 to the flag while the function is present.

Top module: `jack_info_bank`

## Requirements
- R1: Sixteen independent words exist, one per function code. The code is bits 4:1 of the select register at address 0x66. Accesses to the information address 0x68 reach only the word of the selected code.
- R2: The information word layout is: gain in bits 15:11, inversion in bit 10, delay in bits 9:5, valid flag in bit 4, function-present in bit 0. Bits 3:1 read as 0.
- R3: After power-on reset (por_n low), every word has gain 0, inversion 0 and valid 0, and the delay holds its per-function default (4 by default). The select register reads 0.
- R4: A codec reset (codec_rst_n low at a clock edge) clears the select register. It leaves every information word unchanged.
- R5: Function-present reads `func_cap[fc]` and cannot be written.
- R6: When function-present reads 0, the gain, inversion and delay fields read 0 and writes to them are ignored.
- R7: When function-present is 1, writing 1 to bit 4 clears the valid flag. Writing 0 to bit 4 leaves it unchanged.
- R8: A `sense_done` pulse with `sense_fc` equal to f sets the valid flag of word f.
- R9: If a sense completion and a write of 1 to the valid flag reach the same word in the same cycle, the valid flag reads 1 afterward.
- R10: When function-present is 0, the valid flag is read-only.
- R11: While select bit 0 (tip/ring) is 1, a function marked in `mono_mask` reads function-present 0 and is gated as in R6. While the bit is 0, that function behaves normally. Functions not in `mono_mask` are unaffected by the bit.
- R12: Read data and `reg_rvalid` appear one clock after `reg_rd`. The select register reads back as {fc in bits 4:1, tip/ring in bit 0}. Any other address reads 0.
- R13: Writes to any address other than 0x68 leave all information words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| codec_rst_n | input | 1 | Synchronous codec reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| func_cap | input | 16 | Per-function capability, bit f for function f |
| mono_mask | input | 16 | Marks mono functions subject to tip/ring gating |
| sense_done | input | 1 | Sense cycle completion pulse |
| sense_fc | input | 4 | Function code of the completed sense cycle |

## Verification
The hardest case to reach is a sense completion and a write-1-clear of the same valid flag landing in one clock edge. The stimulus drives `sense_done`, `sense_fc`, `reg_wr` and the clearing data on a single falling edge, so that both events meet at the same rising edge. The tip/ring gating of a mono function is also checked. Values are written while the function is visible, hidden by setting ring, and then revealed again. Another check confirms that a codec reset clears the select register while stored words survive it.

// File: rtl/jib_pkg.sv
package jib_pkg;
    localparam int NUM_FC   = 16;
    localparam int FC_W     = $clog2(NUM_FC);
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 7;
    localparam int GAIN_W   = 5;
    localparam int DLY_W    = 5;

    // field positions, decoded by software
    localparam int GAIN_LSB = 11;
    localparam int INV_BIT  = 10;
    localparam int DLY_LSB  = 5;
    localparam int IV_BIT   = 4;
    localparam int FIP_BIT  = 0;

    // writable part of the word handed to a bank (bits 15:4)
    localparam int UPPER_W  = WORD_W - IV_BIT;

    localparam logic [ADDR_W-1:0] SEL_ADDR  = 7'h66;
    localparam logic [ADDR_W-1:0] INFO_ADDR = 7'h68;

    typedef enum logic {
        AC_IDLE = 1'b0,
        AC_RESP = 1'b1
    } acc_state_t;

    typedef enum logic {
        IV_PENDING = 1'b0,
        IV_VALID   = 1'b1
    } iv_state_t;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              inv;
        logic [DLY_W-1:0]  dly;
    } jack_fields_t;
endpackage

// File: rtl/jib_select_reg.sv
module jib_select_reg
    import jib_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic            codec_rst_n,
    input  logic            wr_hit,
    input  logic [FC_W:0]   wdata,
    output logic [FC_W-1:0] fc,
    output logic            tip_ring
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fc       <= '0;
            tip_ring <= 1'b0;
        end else if (!codec_rst_n) begin
            fc       <= '0;
            tip_ring <= 1'b0;
        end else if (wr_hit) begin
            fc       <= wdata[FC_W:1];
            tip_ring <= wdata[0];
        end
    end

    // R4
    sel_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !codec_rst_n |=> (fc == '0) && !tip_ring);
endmodule

// File: rtl/jib_bank.sv
module jib_bank
    import jib_pkg::*;
#(
    parameter logic [DLY_W-1:0] DLY_RST = 5'd4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               fip_eff,
    input  logic               wr_hit,
    input  logic [UPPER_W-1:0] wdata,
    input  logic               sense_hit,
    output logic [WORD_W-1:0]  word_o
);
    jack_fields_t fields;
    iv_state_t    iv_state;
    iv_state_t    iv_next;

    wire clr_req = wr_hit && fip_eff && wdata[0];

    // editable fields, power-on domain only
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fields.gain <= '0;
            fields.inv  <= 1'b0;
            fields.dly  <= DLY_RST;
        end else if (wr_hit && fip_eff) begin
            fields.gain <= wdata[GAIN_LSB-IV_BIT +: GAIN_W];
            fields.inv  <= wdata[INV_BIT-IV_BIT];
            fields.dly  <= wdata[DLY_LSB-IV_BIT +: DLY_W];
        end
    end

    // valid-flag state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) iv_state <= IV_PENDING;
        else        iv_state <= iv_next;
    end

    // valid-flag transitions; sense completion wins over a clear
    always_comb begin
        iv_next = iv_state;
        unique case (iv_state)
            IV_PENDING: if (sense_hit) iv_next = IV_VALID;
            IV_VALID:   if (clr_req && !sense_hit) iv_next = IV_PENDING;
            default:    iv_next = IV_PENDING;
        endcase
    end

    // read view with gating
    always_comb begin
        word_o = '0;
        word_o[IV_BIT] = (iv_state == IV_VALID);
        if (fip_eff) begin
            word_o[GAIN_LSB +: GAIN_W] = fields.gain;
            word_o[INV_BIT]            = fields.inv;
            word_o[DLY_LSB +: DLY_W]   = fields.dly;
            word_o[FIP_BIT]            = 1'b1;
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!por_n)
        sense_hit |=> iv_state == IV_VALID);
    // R6
    gated_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && !fip_eff) |=> $stable(fields));
    // R7
    w0_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
        (wr_hit && !wdata[0] && iv_state == IV_VALID) |=> iv_state == IV_VALID);
    // R10
    ro_iv_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!fip_eff && iv_state == IV_VALID) |=> iv_state == IV_VALID);
    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!wr_hit && !sense_hit) |=> $stable(fields) && $stable(iv_state));
endmodule

// File: rtl/jib_access.sv
module jib_access
    import jib_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              codec_rst_n,
    input  logic              rd,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    acc_state_t state;
    acc_state_t state_next;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)            state <= AC_IDLE;
        else if (!codec_rst_n) state <= AC_IDLE;
        else                   state <= state_next;
    end

    always_comb begin
        state_next = state;
        unique case (state)
            AC_IDLE: if (rd) state_next = AC_RESP;
            AC_RESP: if (!rd) state_next = AC_IDLE;
            default: state_next = AC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             rdata <= '0;
        else if (!codec_rst_n)  rdata <= '0;
        else if (rd)            rdata <= rd_word;
    end

    assign rvalid = (state == AC_RESP);

    // R12
    rvalid_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rd && codec_rst_n) |=> rvalid);
    // R12
    no_rd_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rd |=> !rvalid);
endmodule

// File: rtl/jack_info_bank.sv
module jack_info_bank
    import jib_pkg::*;
#(
    parameter logic [NUM_FC*DLY_W-1:0] DLY_DEFAULTS = {NUM_FC{5'd4}}
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              codec_rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic [NUM_FC-1:0] func_cap,
    input  logic [NUM_FC-1:0] mono_mask,
    input  logic              sense_done,
    input  logic [FC_W-1:0]   sense_fc
);
    logic [FC_W-1:0]   sel_fc;
    logic              sel_tr;
    logic [NUM_FC-1:0] fip_eff;
    logic [WORD_W-1:0] bank_word [NUM_FC];
    logic [WORD_W-1:0] rd_word;

    wire sel_wr  = reg_wr && (reg_addr == SEL_ADDR);
    wire info_wr = reg_wr && (reg_addr == INFO_ADDR);

    jib_select_reg u_sel (
        .clk         (clk),
        .por_n       (por_n),
        .codec_rst_n (codec_rst_n),
        .wr_hit      (sel_wr),
        .wdata       (reg_wdata[FC_W:0]),
        .fc          (sel_fc),
        .tip_ring    (sel_tr)
    );

    for (genvar f = 0; f < NUM_FC; f++) begin : g_bank
        assign fip_eff[f] = func_cap[f] && !(mono_mask[f] && sel_tr);

        jib_bank #(
            .DLY_RST (DLY_DEFAULTS[f*DLY_W +: DLY_W])
        ) u_bank (
            .clk       (clk),
            .por_n     (por_n),
            .fip_eff   (fip_eff[f]),
            .wr_hit    (info_wr && (sel_fc == FC_W'(f))),
            .wdata     (reg_wdata[WORD_W-1:IV_BIT]),
            .sense_hit (sense_done && (sense_fc == FC_W'(f))),
            .word_o    (bank_word[f])
        );
    end

    always_comb begin
        rd_word = '0;
        if (reg_addr == INFO_ADDR)     rd_word = bank_word[sel_fc];
        else if (reg_addr == SEL_ADDR) rd_word[FC_W:0] = {sel_fc, sel_tr};
    end

    jib_access u_acc (
        .clk         (clk),
        .por_n       (por_n),
        .codec_rst_n (codec_rst_n),
        .rd          (reg_rd),
        .rd_word     (rd_word),
        .rdata       (reg_rdata),
        .rvalid      (reg_rvalid)
    );

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rd && reg_addr == INFO_ADDR && codec_rst_n) |=> reg_rdata[3:1] == 3'b000);
endmodule

// File: tb/jack_info_bank_bench.sv
module jack_info_bank_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        codec_rst_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic [15:0] func_cap = 16'hFFF7;
    logic [15:0] mono_mask = 16'h0004;
    logic        sense_done = 1'b0;
    logic [3:0]  sense_fc = '0;

    int tests = 0;
    int fails = 0;

    localparam logic [6:0] A_SEL  = 7'h66;
    localparam logic [6:0] A_INFO = 7'h68;

    always #2.5 clk = ~clk;

    jack_info_bank u_jack_info_bank (
        .clk(clk), .por_n(por_n), .codec_rst_n(codec_rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .func_cap(func_cap), .mono_mask(mono_mask),
        .sense_done(sense_done), .sense_fc(sense_fc)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [6:0] a, logic [15:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check({req, " rvalid"}, {15'b0, reg_rvalid}, 16'h0001);
        check(req, reg_rdata, exp);
    endtask

    task automatic sense(logic [3:0] f);
        @(negedge clk);
        sense_done = 1'b1; sense_fc = f;
        @(negedge clk);
        sense_done = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R3 select", A_SEL, 16'h0000);
        rd_check("R3 fc0 word", A_INFO, 16'h0081);
        @(negedge clk);
        check("R12 idle rvalid", {15'b0, reg_rvalid}, 16'h0000);
    endtask

    task automatic t_fields;
        wr(A_SEL, 16'h0002);
        rd_check("R12 select readback", A_SEL, 16'h0002);
        wr(A_INFO, 16'hFFFF);
        rd_check("R2 R5 fc1 full write", A_INFO, 16'hFFE1);
        wr(A_SEL, 16'h0000);
        rd_check("R1 fc0 untouched", A_INFO, 16'h0081);
        wr(A_SEL, 16'h0002);
    endtask

    task automatic t_sense;
        sense(4'd1);
        rd_check("R8 sense sets", A_INFO, 16'hFFF1);
        wr(A_INFO, 16'hFFE0);
        rd_check("R7 write0 keeps", A_INFO, 16'hFFF1);
        wr(A_INFO, 16'hFFF0);
        rd_check("R7 w1c clears", A_INFO, 16'hFFE1);
    endtask

    task automatic t_prio;
        sense(4'd1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_INFO; reg_wdata = 16'hFFF0;
        sense_done = 1'b1; sense_fc = 4'd1;
        @(negedge clk);
        reg_wr = 1'b0; sense_done = 1'b0;
        rd_check("R9 set wins", A_INFO, 16'hFFF1);
    endtask

    task automatic t_nocap;
        wr(A_SEL, 16'h0006);
        wr(A_INFO, 16'hFFFF);
        rd_check("R6 gated write", A_INFO, 16'h0000);
        sense(4'd3);
        rd_check("R8 sense uncapable", A_INFO, 16'h0010);
        wr(A_INFO, 16'h0010);
        rd_check("R10 iv read-only", A_INFO, 16'h0010);
    endtask

    task automatic t_mono;
        wr(A_SEL, 16'h0004);
        wr(A_INFO, 16'h1234);
        rd_check("R11 tip normal", A_INFO, 16'h1221);
        wr(A_SEL, 16'h0005);
        rd_check("R11 ring gated", A_INFO, 16'h0000);
        wr(A_INFO, 16'hFFFF);
        wr(A_SEL, 16'h0004);
        rd_check("R11 tip restored", A_INFO, 16'h1221);
        wr(A_SEL, 16'h0003);
        rd_check("R11 stereo unaffected", A_INFO, 16'hFFF1);
    endtask

    task automatic t_other;
        wr(A_SEL, 16'h0002);
        wr(7'h6A, 16'h0000);
        wr(7'h00, 16'h0010);
        rd_check("R13 bank intact", A_INFO, 16'hFFF1);
        rd_check("R12 other addr", 7'h6A, 16'h0000);
    endtask

    task automatic t_codec_rst;
        @(negedge clk);
        codec_rst_n = 1'b0;
        @(negedge clk);
        codec_rst_n = 1'b1;
        rd_check("R4 select cleared", A_SEL, 16'h0000);
        wr(A_SEL, 16'h0002);
        rd_check("R4 fc1 kept", A_INFO, 16'hFFF1);
        wr(A_SEL, 16'h0004);
        rd_check("R4 fc2 kept", A_INFO, 16'h1221);
    endtask

    task automatic t_por;
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        rd_check("R3 select after por", A_SEL, 16'h0000);
        wr(A_SEL, 16'h0002);
        rd_check("R3 fc1 after por", A_INFO, 16'h0081);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset();
        t_fields();
        t_sense();
        t_prio();
        t_nocap();
        t_mono();
        t_other();
        t_codec_rst();
        t_por();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule